// File: doc/BRIEF.md
# Bit-Addressable GPIO Port

This block is a 32-bit general-purpose I/O port on a small register bus. Each access is one cycle and carries an address, a write strobe, write data, a read strobe and read data. The port holds three writable registers. The pin-value register drives the pin output levels. The pin-direction register drives the per-pin output enables. The status register is a general-purpose word that software can read and write.

Each writable register can be written directly, which replaces its whole value. Each one also has two alias addresses. Writing ones to the set alias turns bits on, and writing ones to the clear alias turns bits off, so software can change single bits without a read-modify-write sequence. The external pin levels pass through a two-stage synchroniser into a read-only input register.

All registers reset to zero, so after reset every pin is an input and every output level is low. Reads are registered: the data appears one cycle after the read strobe and holds until the next read.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted and just after it is released, `pin_out`, `pin_oe` and `bus_rdata` are zero, and the output, direction and status registers read back as zero.
- R2: A write to the base offset of a register replaces its whole value on the clock edge that samples the write strobe. The base offsets are 0x00 for output, 0x0C for direction and 0x1C for status.
- R3: A write to the set alias (base + 0x04: 0x04, 0x10, 0x20) ORs the write data into the target register. Bits written as 0 keep their value.
- R4: A write to the clear alias (base + 0x08: 0x08, 0x14, 0x24) clears exactly the bits written as 1 in the target register. All other bits keep their value.
- R5: A read of any set or clear alias returns zero.
- R6: `pin_out` always equals the output register. `pin_oe` always equals the direction register, where bit value 1 means the pin is an output.
- R7: The input register at offset 0x18 shows `pin_in` after two synchroniser stages. A read whose strobe is sampled on the third rising edge after a pin change returns the new level. A read sampled on the first or second edge returns the old level.
- R8: A write to offset 0x18 or to any unmapped offset changes no register and no pin.
- R9: A read of an unmapped offset returns zero.
- R10: `bus_rdata` is updated on the edge that samples `bus_rd`, so it is valid one cycle later. It holds its value while `bus_rd` is low, even if the registers change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | External pin levels (asynchronous) |
| pin_out | output | 32 | Pin output levels |
| pin_oe | output | 32 | Pin output enables, 1 = output |

## Verification
Each register is loaded directly with alternating and sparse patterns, such as 0xA5A5_5A5A and single-bit words. These show whether the whole word is replaced or only some bits are merged. Set and clear aliases are then written with masks that overlap some ones and some zeros already in the target. This separates a true OR or AND-NOT from a plain load and from a write to the wrong register. Reads of the aliases, of unmapped offsets and of the input register are timed after a pin change. They separate the zero-return rules, the read hold behaviour and the exact depth of the synchroniser.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Register offsets (byte addresses)
  localparam int OFF_OUT   = 'h00;
  localparam int OFF_DIR   = 'h0C;
  localparam int OFF_IN    = 'h18;
  localparam int OFF_STS   = 'h1C;
  localparam int SET_STEP  = 'h04;
  localparam int CLR_STEP  = 'h08;

  // Number of writable registers and their indices
  localparam int NREG      = 3;
  localparam int IDX_OUT   = 0;
  localparam int IDX_DIR   = 1;
  localparam int IDX_STS   = 2;

  typedef enum logic [1:0] {
    WOP_NONE = 2'd0,
    WOP_LOAD = 2'd1,
    WOP_SET  = 2'd2,
    WOP_CLR  = 2'd3
  } wop_e;

  function automatic int reg_base(input int idx);
    case (idx)
      IDX_OUT: reg_base = OFF_OUT;
      IDX_DIR: reg_base = OFF_DIR;
      default: reg_base = OFF_STS;
    endcase
  endfunction

endpackage

// File: rtl/gpio_bitreg.sv
module gpio_bitreg
  import gpio_port_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  wop_e         op,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;
  logic         q_en;

  // Next-state logic
  always_comb begin
    q_en  = 1'b1;
    q_nxt = q;
    case (op)
      WOP_LOAD: q_nxt = wdata;
      WOP_SET:  q_nxt = q | wdata;
      WOP_CLR:  q_nxt = q & ~wdata;
      default:  q_en  = 1'b0;
    endcase
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end

  a_r2_load_replaces: assert property (@(posedge clk) disable iff (!rst_n)
    (op == WOP_LOAD) |=> (q == $past(wdata)));

  a_r3_set_keeps_and_adds: assert property (@(posedge clk) disable iff (!rst_n)
    (op == WOP_SET) |=> (((q & $past(wdata)) == $past(wdata)) && ((q & $past(q)) == $past(q))));

  a_r4_clear_only_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (op == WOP_CLR) |=> (((q & $past(wdata)) == '0) && ((q | $past(wdata)) == ($past(q) | $past(wdata)))));

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (op == WOP_NONE) |=> $stable(q));

endmodule

// File: rtl/gpio_insync.sv
module gpio_insync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;
  logic [W-1:0] stage1_nxt;
  logic [W-1:0] q_nxt;

  always_comb begin
    stage1_nxt = d;
    q_nxt      = stage1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= stage1_nxt;
      q      <= q_nxt;
    end
  end

  a_r7_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 1'b1 |=> (q == $past(d, 2)));

endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_port_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      out_q,
  input  logic [W-1:0]      dir_q,
  input  logic [W-1:0]      sts_q,
  input  logic [W-1:0]      in_q,
  output logic [W-1:0]      rdata
);

  localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(OFF_OUT);
  localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(OFF_DIR);
  localparam logic [ADDR_W-1:0] A_IN  = ADDR_W'(OFF_IN);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFF_STS);

  logic [W-1:0] sel;
  logic [W-1:0] rdata_nxt;
  logic         rdata_en;
  logic         hit;

  // Aliases and unmapped offsets fall through to zero
  always_comb begin
    hit = 1'b1;
    case (addr)
      A_OUT:   sel = out_q;
      A_DIR:   sel = dir_q;
      A_IN:    sel = in_q;
      A_STS:   sel = sts_q;
      default: begin
        sel = '0;
        hit = 1'b0;
      end
    endcase
    rdata_en  = rd;
    rdata_nxt = sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata <= '0;
    else if (rdata_en) rdata <= rdata_nxt;
  end

  a_r9_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !hit) |=> (rdata == '0));

  a_r10_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));

  a_r10_out_read_value: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == A_OUT) |=> (rdata == $past(out_q)));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [W-1:0]      bus_wdata,
  input  logic              bus_rd,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe
);

  logic [W-1:0] reg_q [NREG];
  wop_e         reg_op [NREG];
  logic [W-1:0] in_q;

  // One register instance per writable register, each with its own decoder
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(reg_base(i));
    localparam logic [ADDR_W-1:0] ASET = ADDR_W'(reg_base(i) + SET_STEP);
    localparam logic [ADDR_W-1:0] ACLR = ADDR_W'(reg_base(i) + CLR_STEP);

    always_comb begin
      reg_op[i] = WOP_NONE;
      if (bus_wr) begin
        if (bus_addr == BASE)      reg_op[i] = WOP_LOAD;
        else if (bus_addr == ASET) reg_op[i] = WOP_SET;
        else if (bus_addr == ACLR) reg_op[i] = WOP_CLR;
      end
    end

    gpio_bitreg #(.W(W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (reg_op[i]),
      .wdata (bus_wdata),
      .q     (reg_q[i])
    );
  end

  gpio_insync #(.W(W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (in_q)
  );

  gpio_rdmux #(.W(W), .ADDR_W(ADDR_W)) u_rd (
    .clk   (clk),
    .rst_n (rst_n),
    .rd    (bus_rd),
    .addr  (bus_addr),
    .out_q (reg_q[IDX_OUT]),
    .dir_q (reg_q[IDX_DIR]),
    .sts_q (reg_q[IDX_STS]),
    .in_q  (in_q),
    .rdata (bus_rdata)
  );

  assign pin_out = reg_q[IDX_OUT];
  assign pin_oe  = reg_q[IDX_DIR];

  localparam logic [ADDR_W-1:0] A_OSET = ADDR_W'(OFF_OUT + SET_STEP);
  localparam logic [ADDR_W-1:0] A_DCLR = ADDR_W'(OFF_DIR + CLR_STEP);
  localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(OFF_IN);

  a_r5_alias_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == A_OSET || bus_addr == A_DCLR)) |=> (bus_rdata == '0));

  a_r8_input_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_IN) |=> ($stable(pin_out) && $stable(pin_oe)));

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (pin_out == '0 && pin_oe == '0 && bus_rdata == '0));

endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic        bus_rd;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  gpio_port uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    rd(8'h00, v); check("R1 out reg", v, 32'h0);
    rd(8'h0C, v); check("R1 dir reg", v, 32'h0);
    rd(8'h1C, v); check("R1 sts reg", v, 32'h0);
  endtask

  task automatic t_direct();
    logic [31:0] v;
    wr(8'h00, 32'hA5A5_5A5A); check("R2 out load pin", pin_out, 32'hA5A5_5A5A);
    wr(8'h00, 32'h0000_0100); check("R2 out replace", pin_out, 32'h0000_0100);
    wr(8'h0C, 32'hF0F0_000F); check("R2 dir load", pin_oe, 32'hF0F0_000F);
    wr(8'h1C, 32'h1234_5678);
    rd(8'h1C, v); check("R2 sts readback", v, 32'h1234_5678);
    rd(8'h00, v); check("R2 out readback", v, 32'h0000_0100);
  endtask

  task automatic t_set();
    logic [31:0] v;
    wr(8'h04, 32'h8000_0101); check("R3 out set", pin_out, 32'h8000_0101);
    wr(8'h10, 32'h0F00_0001); check("R3 dir set", pin_oe, 32'hFFF0_000F);
    wr(8'h20, 32'h0000_0081);
    rd(8'h1C, v); check("R3 sts set", v, 32'h1234_56F9);
    check("R6 oe follows dir", pin_oe, 32'hFFF0_000F);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(8'h08, 32'h8000_0010); check("R4 out clear", pin_out, 32'h0000_0101);
    wr(8'h14, 32'h00F0_0003); check("R4 dir clear", pin_oe, 32'hFF00_000C);
    wr(8'h24, 32'h1000_0008);
    rd(8'h1C, v); check("R4 sts clear", v, 32'h0234_56F1);
  endtask

  task automatic t_alias_zero();
    logic [31:0] v;
    rd(8'h00, v);
    rd(8'h04, v); check("R5 out set alias", v, 32'h0);
    rd(8'h0C, v);
    rd(8'h14, v); check("R5 dir clear alias", v, 32'h0);
    rd(8'h1C, v);
    rd(8'h20, v); check("R5 sts set alias", v, 32'h0);
  endtask

  task automatic t_input_sync();
    logic [31:0] v;
    @(negedge clk); pin_in = 32'hC3C3_3C3C;
    bus_addr = 8'h18; bus_rd = 1'b1;
    @(negedge clk); check("R7 first edge old", bus_rdata, 32'h0);
    @(negedge clk); check("R7 second edge old", bus_rdata, 32'h0);
    @(negedge clk); check("R7 third edge new", bus_rdata, 32'hC3C3_3C3C);
    bus_rd = 1'b0;
    rd(8'h18, v); check("R7 stable value", v, 32'hC3C3_3C3C);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    check("R8 pin_out kept", pin_out, 32'h0000_0101);
    check("R8 pin_oe kept", pin_oe, 32'hFF00_000C);
    rd(8'h1C, v); check("R8 sts kept", v, 32'h0234_56F1);
    rd(8'h18, v); check("R8 input kept", v, 32'hC3C3_3C3C);
  endtask

  task automatic t_unmapped_read();
    logic [31:0] v;
    rd(8'h1C, v);
    rd(8'h28, v); check("R9 unmapped 0x28", v, 32'h0);
    rd(8'h1C, v);
    rd(8'h03, v); check("R9 unmapped 0x03", v, 32'h0);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    rd(8'h00, v); check("R10 read latency", v, 32'h0000_0101);
    wr(8'h00, 32'h5555_0000);
    repeat (3) @(negedge clk);
    check("R10 hold while idle", bus_rdata, 32'h0000_0101);
    rd(8'h00, v); check("R10 fresh read", v, 32'h5555_0000);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    bus_rd = 1'b0; pin_in = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", pin_out | pin_oe | bus_rdata, 32'h0);
    rst_n = 1'b1;
    t_reset();
    t_direct();
    t_set();
    t_clear();
    t_alias_zero();
    t_input_sync();
    t_ignored();
    t_unmapped_read();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule